// File: doc/BRIEF.md
# Dual-lane converter serial output port

This block is the serial read-back side of an eight-channel, 18-bit simultaneous-sampling converter. It latches one word per channel when the conversion-busy input falls. It then shifts those words out MSB first on two data lanes, A and B. An external serial clock drives the shifting, and an active-low select frames the transfer. The port logic runs on a system clock `clk`. It samples `sclk`, `cs_n` and `busy` once per `clk` edge, detects their edges, and changes its outputs one `clk` cycle after it sees an edge.

A two-bit mode input chooses the lane arrangement:
- 0 or 3: both lanes are in use.
- 1: lane A carries every channel.
- 2: lane B carries every channel.

A first-channel flag tells the reader when channel 1 is about to come out on lane A. The tri-state behaviour of the real pins is shown by `out_en`, which is high only while the port is selected. While `out_en` is low, the flag is held low.

The parallel input `conv_words` packs channel 1 into bits [17:0], channel 2 into bits [35:18], and so on up to channel 8.

Top module: `adc_sport_top`

## Requirements
- R1: The eight words go into an internal bank only on a falling edge of `busy`. Any change on `conv_words` at another time leaves the data read out unchanged.
- R2: `out_en` follows the select. It is 0 after reset and while `cs_n` is high, and 1 while `cs_n` is low. While `out_en` is 0, `first_flag` is 0.
- R3: Each channel takes exactly 18 `sclk` cycles and is sent MSB first. The MSB is presented when the select falls or the channel starts. Each later bit appears after an `sclk` rising edge and is meant to be sampled at the next falling edge.
- R4: In mode 0 (or 3), lane A sends channels 1, 2, 3, 4 and lane B sends channels 5, 6, 7, 8 at the same time, for a 72-cycle frame.
- R5: In mode 1, lane A sends channels 1 to 8 in ascending order over 144 cycles, and lane B stays 0.
- R6: In mode 2, lane B sends channels 5, 6, 7, 8, 1, 2, 3, 4 over 144 cycles, and lane A stays 0.
- R7: `sclk` edges are ignored while `cs_n` is high. If the select is pulsed once per 18-cycle channel, the read continues with the next channel rather than restarting.
- R8: While selected, `first_flag` is 1 exactly when channel 1 is the current channel on lane A. It drops after the 18th `sclk` falling edge of that channel.
- R9: In mode 2, `first_flag` is never 1, including while channel 1 is being sent on lane B.
- R10: A falling edge of `busy` returns the read position to the first channel and first bit of the selected order, even in the middle of a frame.
- R11: Once every channel of the selected order has been sent, both lanes output 0 until the next falling edge of `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial inputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy | input | 1 | Conversion busy; its falling edge latches the words |
| conv_words | input | 144 | Eight packed 18-bit results, channel 1 in the lowest bits |
| lane_mode | input | 2 | 0/3 both lanes, 1 lane A only, 2 lane B only |
| cs_n | input | 1 | Active-low select framing the read |
| sclk | input | 1 | Serial shift clock from the reader |
| dout_a | output | 1 | Serial data, lane A |
| dout_b | output | 1 | Serial data, lane B |
| first_flag | output | 1 | High while channel 1 is current on lane A |
| out_en | output | 1 | Output drivers enabled (low means high impedance) |

## Verification
The hardest situation to reach from the ports is a new conversion landing in the middle of a frame. The bank must take the new words and the read position must rewind, while the flag logic still has to treat channel 1 correctly. The stimulus reads two channels of a dual-lane frame, raises the select, and pulses `busy` with a fresh set of words. It then expects channel 1 of the new set, with the flag high. A second hard case is the per-channel select pulsing in single-lane modes, combined with a change on `conv_words` that has no `busy` edge. This shows that the pointer survives deselection and that the bank ignores the bus.

// File: rtl/adc_sport_pkg.sv
package adc_sport_pkg;

  typedef enum logic [1:0] {
    LM_DUAL     = 2'd0,
    LM_A_ONLY   = 2'd1,
    LM_B_ONLY   = 2'd2,
    LM_DUAL_ALT = 2'd3
  } lane_mode_e;

  // Number of channel slots each active lane walks through.
  function automatic int unsigned slots_per_lane(lane_mode_e m, int unsigned nch);
    if (m == LM_A_ONLY || m == LM_B_ONLY) return nch;
    return nch / 2;
  endfunction

  // Whether a lane (0 = A, 1 = B) carries data in this mode.
  function automatic logic lane_active(lane_mode_e m, int unsigned lane);
    if (m == LM_A_ONLY) return (lane == 0);
    if (m == LM_B_ONLY) return (lane == 1);
    return 1'b1;
  endfunction

  // Zero-based channel sent on a lane at a given slot.
  function automatic int unsigned chan_index(lane_mode_e m, int unsigned lane,
                                             int unsigned slot, int unsigned nch);
    int unsigned half;
    half = nch / 2;
    if (lane == 0) return slot;
    if (m == LM_B_ONLY) return (slot + half) % nch;
    return slot + half;
  endfunction

endpackage

// File: rtl/adc_edge_detect.sv
module adc_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic busy,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic busy_fall,
  output logic cs_act
);
  logic sclk_q, cs_q, busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b1;
      cs_q   <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
      busy_q <= busy;
    end
  end

  assign sclk_rise = sclk & ~sclk_q;
  assign sclk_fall = ~sclk & sclk_q;
  assign busy_fall = ~busy & busy_q;
  assign cs_act    = ~cs_q;

endmodule

// File: rtl/adc_word_bank.sv
module adc_word_bank #(
  parameter int unsigned NCH = 8,
  parameter int unsigned W   = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy_fall,
  input  logic [NCH*W-1:0] words_in,
  output logic [W-1:0]     bank [NCH]
);

  for (genvar c = 0; c < NCH; c++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         bank[c] <= '0;
      else if (busy_fall) bank[c] <= words_in[c*W +: W];
    end

    p_bank_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_fall |=> $stable(bank[c]))
      else $error("bank word changed without busy falling edge");
  end

endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
  import adc_sport_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned W   = 18,
  localparam int unsigned SW = $clog2(NCH + 1),
  localparam int unsigned BW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy_fall,
  input  logic          sclk_rise,
  input  logic          sclk_fall,
  input  logic          cs_act,
  input  lane_mode_e    mode,
  output logic [SW-1:0] slot,
  output logic [BW-1:0] bidx,
  output logic          done,
  output logic          ch_end
);
  logic [BW-1:0] fcnt;   // falling edges seen in the current channel

  assign done   = (slot >= SW'(slots_per_lane(mode, NCH)));
  assign ch_end = cs_act && !done && sclk_fall && (fcnt == BW'(W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot <= '0;
      fcnt <= '0;
      bidx <= '0;
    end else if (busy_fall) begin
      slot <= '0;
      fcnt <= '0;
      bidx <= '0;
    end else if (cs_act && !done) begin
      if (sclk_fall) begin
        if (fcnt == BW'(W - 1)) begin
          slot <= slot + 1'b1;
          fcnt <= '0;
          bidx <= '0;
        end else begin
          fcnt <= fcnt + 1'b1;
        end
      end else if (sclk_rise && bidx < fcnt) begin
        bidx <= fcnt;
      end
    end
  end

  p_ptr_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_fall |=> (slot == '0 && bidx == '0))
    else $error("pointer not rewound after busy fall");

  p_bit_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bidx <= fcnt) && (fcnt < BW'(W)))
    else $error("bit index out of range");

  p_hold_deselect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_act && !busy_fall) |=> $stable(slot))
    else $error("channel pointer moved while deselected");

  p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ch_end |=> (bidx == '0 && slot == $past(slot) + 1'b1))
    else $error("channel did not advance after 18th falling edge");

endmodule

// File: rtl/adc_sport_top.sv
module adc_sport_top
  import adc_sport_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned W   = 18,
  localparam int unsigned SW = $clog2(NCH + 1),
  localparam int unsigned BW = $clog2(W),
  localparam int unsigned CW = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic [NCH*W-1:0] conv_words,
  input  logic [1:0]       lane_mode,
  input  logic             cs_n,
  input  logic             sclk,
  output logic             dout_a,
  output logic             dout_b,
  output logic             first_flag,
  output logic             out_en
);
  lane_mode_e    mode;
  logic          sclk_rise, sclk_fall, busy_fall, cs_act;
  logic [W-1:0]  bank [NCH];
  logic [SW-1:0] slot;
  logic [BW-1:0] bidx;
  logic          done, ch_end;
  logic [1:0]    lane_bit;
  logic [BW-1:0] bitpos;
  logic [CW-1:0] a_chan;

  assign mode   = lane_mode_e'(lane_mode);
  assign bitpos = BW'(W - 1) - bidx;

  adc_edge_detect u_edge (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .busy(busy),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .busy_fall(busy_fall), .cs_act(cs_act)
  );

  adc_word_bank #(.NCH(NCH), .W(W)) u_bank (
    .clk(clk), .rst_n(rst_n), .busy_fall(busy_fall),
    .words_in(conv_words), .bank(bank)
  );

  adc_frame_seq #(.NCH(NCH), .W(W)) u_seq (
    .clk(clk), .rst_n(rst_n), .busy_fall(busy_fall),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_act(cs_act),
    .mode(mode), .slot(slot), .bidx(bidx), .done(done), .ch_end(ch_end)
  );

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [CW-1:0] chan;
    logic [W-1:0]  word;
    assign chan = CW'(chan_index(mode, g, int'(slot), NCH));
    assign word = bank[chan];
    assign lane_bit[g] = lane_active(mode, g) && !done && word[bitpos];
  end

  assign a_chan     = CW'(chan_index(mode, 0, int'(slot), NCH));
  assign dout_a     = lane_bit[0];
  assign dout_b     = lane_bit[1];
  assign out_en     = cs_act;
  assign first_flag = cs_act && !done && lane_active(mode, 0) && (a_chan == '0);

  p_flag_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> !first_flag)
    else $error("flag high while deselected");

  p_flag_bonly_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == LM_B_ONLY) |-> !first_flag)
    else $error("flag high in lane-B-only mode");

  p_flag_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_end && first_flag && !busy_fall) |=> !first_flag)
    else $error("flag still high after channel 1 completed");

  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!dout_a && !dout_b))
    else $error("data on lanes after frame end");

endmodule

// File: tb/adc_sport_top_tb.sv
module adc_sport_top_tb;
  localparam int NCH = 8;
  localparam int W   = 18;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             busy = 1'b0;
  logic [NCH*W-1:0] conv_words = '0;
  logic [1:0]       lane_mode = 2'd0;
  logic             cs_n = 1'b1;
  logic             sclk = 1'b1;
  logic             dout_a, dout_b, first_flag, out_en;

  int checks = 0;
  int failures = 0;
  logic [W-1:0] exp_bank [NCH];
  int           rd_slot;
  logic [1:0]   q_exp [$];
  string        q_tag [$];
  event         smp_ev;
  bit           finished = 0;

  always #5 clk = ~clk;

  adc_sport_top u_dut (
    .clk(clk), .rst_n(rst_n), .busy(busy), .conv_words(conv_words),
    .lane_mode(lane_mode), .cs_n(cs_n), .sclk(sclk),
    .dout_a(dout_a), .dout_b(dout_b), .first_flag(first_flag), .out_en(out_en)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h time=%0t", req, act, exp, $time);
    end
  endtask

  // Monitor: pops expected lane bits and compares against sampled outputs.
  always @(smp_ev) begin
    logic [1:0] e;
    string t;
    if (q_exp.size() == 0) begin
      checks++; failures++;
      $display("FAIL scoreboard actual=empty expected=item");
    end else begin
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      check(t, {30'd0, dout_a, dout_b}, {30'd0, e});
    end
  end

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [W-1:0] mk_word(int seed, int ch);
    return W'((seed * 40503 + ch * 9973 + (ch << 13)) ^ (seed << 4));
  endfunction

  // Expected channel per lane, derived from R4, R5, R6; -1 means zeros.
  function automatic int exp_chan(int mode, int lane, int slot);
    case (mode)
      1: return (lane == 0 && slot < 8) ? slot : -1;
      2: return (lane == 1 && slot < 8) ? (slot ^ 4) : -1;
      default: return (slot < 4) ? (lane == 0 ? slot : slot + 4) : -1;
    endcase
  endfunction

  task automatic load_set(int seed);
    for (int c = 0; c < NCH; c++) begin
      conv_words[c*W +: W] = mk_word(seed, c);
      exp_bank[c] = mk_word(seed, c);
    end
    busy = 1'b1; wclk(3);
    busy = 1'b0; wclk(3);
    rd_slot = 0;
  endtask

  // Driver: pushes the expected bits of one channel, then clocks it out.
  task automatic read_chan(string req, bit pulsed);
    int ca, cb, mode;
    logic [W-1:0] wa, wb;
    mode = int'(lane_mode);
    ca = exp_chan(mode, 0, rd_slot);
    cb = exp_chan(mode, 1, rd_slot);
    wa = (ca < 0) ? '0 : exp_bank[ca];
    wb = (cb < 0) ? '0 : exp_bank[cb];
    for (int i = W - 1; i >= 0; i--) begin
      q_exp.push_back({wa[i], wb[i]});
      q_tag.push_back(req);
    end
    if (pulsed || cs_n) begin cs_n = 1'b0; wclk(4); end
    check("R2 out_en low-select", {31'd0, out_en}, 32'd1);
    check("R8 flag at channel start", {31'd0, first_flag},
          {31'd0, (ca == 0)});
    for (int i = 0; i < W; i++) begin
      -> smp_ev;
      #1;
      sclk = 1'b0; wclk(4);
      sclk = 1'b1; wclk(4);
    end
    rd_slot++;
    if (ca == 0) check("R8 flag drops after 18th fall", {31'd0, first_flag}, 32'd0);
    if (pulsed) begin cs_n = 1'b1; wclk(4); end
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    wclk(3);
    rst_n = 1'b1;
    wclk(2);
    check("R2 reset out_en", {31'd0, out_en}, 32'd0);
    check("R2 reset flag", {31'd0, first_flag}, 32'd0);

    // R4: both lanes, select held for the whole frame; then R11 trailing zeros.
    lane_mode = 2'd0;
    load_set(1);
    for (int k = 0; k < 4; k++) read_chan("R4 R3 dual lane", 1'b0);
    read_chan("R11 zeros past frame", 1'b0);
    cs_n = 1'b1; wclk(4);
    check("R2 out_en after deselect", {31'd0, out_en}, 32'd0);
    check("R2 flag after deselect", {31'd0, first_flag}, 32'd0);

    // R5 with per-channel select pulses (R7); bus changes without busy edge (R1).
    lane_mode = 2'd1;
    load_set(2);
    conv_words = {NCH*W{1'b1}};
    wclk(2);
    sclk = 1'b0; wclk(4); sclk = 1'b1; wclk(4);   // R7: edges while deselected
    for (int k = 0; k < 8; k++) read_chan("R5 R7 R1 lane A only", 1'b1);
    read_chan("R11 zeros after A-only frame", 1'b1);

    // R6 and R9: lane B alone.
    lane_mode = 2'd2;
    load_set(3);
    for (int k = 0; k < 8; k++) begin
      read_chan("R6 lane B only", 1'b1);
      check("R9 flag never high in B-only", {31'd0, first_flag}, 32'd0);
    end

    // R10: new conversion in the middle of a dual frame; mode 3 acts as dual.
    lane_mode = 2'd3;
    load_set(4);
    read_chan("R4 mode3 dual", 1'b0);
    read_chan("R4 mode3 dual", 1'b0);
    cs_n = 1'b1; wclk(4);
    load_set(5);
    for (int k = 0; k < 4; k++) read_chan("R10 rewind after busy fall", 1'b0);
    cs_n = 1'b1; wclk(4);

    check("R3 scoreboard drained", q_exp.size(), 32'd0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule